// File: doc/BRIEF.md
# Automatic Level Control Gain Engine

This block runs the digital control loop that sets the gain code of a microphone input amplifier. Each accepted PCM sample is compared against a limiter threshold. When the sample's magnitude goes above the threshold, the 7-bit gain code is reduced by a programmed number of steps. When a full waiting period of samples passes with no excess, the gain code is raised by a programmed step, but never above a programmed ceiling. One code step is 0.5 dB, code 0x10 is 0 dB and code 0x47 is +27.5 dB.

An optional zero-crossing gate can hold a gain change until the input signal crosses zero. If no crossing arrives in time, a timeout forces the change. The waiting period and the timeout both count accepted samples, so they follow the sample rate rather than the system clock.

The settings are captured while control is off and stay frozen while it runs. A start gain can be written while the path is powered and control is off. When control is switched off, the output keeps the gain that the loop last reached.

Top module: `alc_gain_engine`

## Requirements
- R1: After reset, gain_o is 0x10 (0 dB).
- R2: The start gain is copied to gain_o only on a gain_wr_i pulse while path_on_i=1 and alc_en_i=0. A pulse while path_on_i=0 or while alc_en_i=1 leaves gain_o unchanged.
- R3: A sample exceeds the limit when its magnitude is strictly greater than the level that lvl_sel_i selects. Level 0 is 5/8 of full scale (about -4 dBFS, 20480 for 16 bits). Level 1 is 1/2 of full scale (16384). Negative samples are judged by their magnitude.
- R4: Each excess lowers gain_o by att_sel_i+1 codes, and the result saturates at code 0x00.
- R5: Recovery happens when a run of (128 << tmo_sel_i) consecutive accepted samples contains no excess. It raises gain_o by rec_sel_i+1 codes, clamped to max_gain_i. A gain already at the ceiling is held there.
- R6: Any excess restarts the recovery wait, so no recovery occurs until a full period has passed after the latest excess.
- R7: With zc_en_i=1, a pending change is applied only on a sample whose sign bit differs from the previous accepted sample's sign bit, or on a sample equal to zero.
- R8: With zc_en_i=1, a change still pending after (128 << tmo_sel_i) further accepted samples is applied on that sample.
- R9: When an attenuation and a recovery are due on the same sample, the attenuation is applied and the recovery is dropped.
- R10: The settings lvl_sel_i, att_sel_i, rec_sel_i, zc_en_i, tmo_sel_i and max_gain_i are captured only while alc_en_i=0. Changes made while alc_en_i=1 have no effect.
- R11: While control is inactive (alc_en_i=0 or path_on_i=0) and no load occurs, gain_o keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_valid_i | input | 1 | Sample strobe |
| smp_i | input | DW | Signed PCM sample |
| alc_en_i | input | 1 | Automatic control enable |
| path_on_i | input | 1 | Mic path powered/active |
| gain_wr_i | input | 1 | Start-gain load pulse |
| start_gain_i | input | 7 | Start gain code |
| max_gain_i | input | 7 | Recovery ceiling code |
| lvl_sel_i | input | 1 | Limiter level select |
| att_sel_i | input | 2 | Attenuation steps minus one |
| rec_sel_i | input | 1 | Recovery steps minus one |
| zc_en_i | input | 1 | Zero-crossing gate enable |
| tmo_sel_i | input | 2 | Wait/timeout length code |
| gain_o | output | 7 | Applied gain code |

## Verification
A gain change caused by an accepted sample appears on gain_o one clock after the edge that accepts the sample. The driver therefore queues one expected gain for every sample it sends. The monitor marks the accepting edge and compares the front of the queue at the falling edge that follows.

Start-gain loads and writes that must be ignored are checked at the second falling edge after the pulse. Freeze behaviour is checked after idle cycles. Recovery and timeout are checked on the exact sample at the end of the period, as well as on the sample just before it.

// File: rtl/alc_pkg.sv
package alc_pkg;
  localparam int GAIN_W = 7;
  typedef logic [GAIN_W-1:0] gain_t;

  typedef struct packed {
    logic       lvl_sel;
    logic [1:0] att_sel;
    logic       rec_sel;
    logic       zc_en;
    logic [1:0] tmo_sel;
    gain_t      max_gain;
  } alc_cfg_t;
endpackage

// File: rtl/alc_level_det.sv
module alc_level_det #(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [DW-1:0] smp_i,
  input  logic          lvl_sel_i,
  output logic          exceed_o,
  output logic          zc_o
);
  localparam int FS = 1 << (DW - 1);
  localparam logic [DW-1:0] LVL_HI = DW'(FS / 2 + FS / 8);
  localparam logic [DW-1:0] LVL_LO = DW'(FS / 2);

  logic [DW-1:0] mag;
  logic [DW-1:0] lvl;
  logic          prev_sign_q;

  // two's-complement magnitude; most negative value maps to FS unsigned
  assign mag = smp_i[DW-1] ? (~smp_i + DW'(1)) : smp_i;
  assign lvl = lvl_sel_i ? LVL_LO : LVL_HI;

  assign exceed_o = valid_i && (mag > lvl);
  assign zc_o     = valid_i && ((smp_i == '0) || (smp_i[DW-1] != prev_sign_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      prev_sign_q <= 1'b0;
    else if (valid_i) prev_sign_q <= smp_i[DW-1];
  end

  assert_exceed_strobed_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exceed_o |-> (valid_i && smp_i != '0));
endmodule

// File: rtl/alc_pacer.sv
module alc_pacer #(
  parameter int WAIT_BASE = 128
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       active_i,
  input  logic       valid_i,
  input  logic       exceed_i,
  input  logic       pend_i,
  input  logic [1:0] tmo_sel_i,
  output logic       rec_req_o,
  output logic       tmo_hit_o
);
  localparam int CNT_W = $clog2(WAIT_BASE) + 4;

  logic [CNT_W-1:0] lim;
  logic [CNT_W-1:0] wait_cnt_q;
  logic [CNT_W-1:0] tmo_cnt_q;

  assign lim       = (CNT_W'(WAIT_BASE) << tmo_sel_i) - CNT_W'(1);
  assign rec_req_o = active_i && valid_i && !exceed_i && (wait_cnt_q == lim);
  assign tmo_hit_o = active_i && valid_i && pend_i && (tmo_cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wait_cnt_q <= '0;
    end else if (!active_i) begin
      wait_cnt_q <= '0;
    end else if (valid_i) begin
      if (exceed_i || wait_cnt_q == lim) wait_cnt_q <= '0;
      else                               wait_cnt_q <= wait_cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmo_cnt_q <= '0;
    end else if (!active_i || !pend_i) begin
      tmo_cnt_q <= '0;
    end else if (valid_i) begin
      if (tmo_cnt_q == lim) tmo_cnt_q <= '0;
      else                  tmo_cnt_q <= tmo_cnt_q + CNT_W'(1);
    end
  end

  assert_wait_in_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_cnt_q <= lim);
  assert_excess_restarts_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && exceed_i) |=> (wait_cnt_q == '0));
endmodule

// File: rtl/alc_gain_reg.sv
module alc_gain_reg
  import alc_pkg::*;
#(
  parameter gain_t RESET_GAIN = 7'h10
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       active_i,
  input  logic       load_i,
  input  gain_t      start_i,
  input  logic       exceed_i,
  input  logic       rec_req_i,
  input  logic       zc_i,
  input  logic       tmo_hit_i,
  input  logic       zc_en_i,
  input  logic [1:0] att_sel_i,
  input  logic       rec_sel_i,
  input  gain_t      max_i,
  output gain_t      gain_o,
  output logic       pend_o
);
  gain_t          gain_q;
  logic           pend_att_q, pend_rec_q;
  logic           want_att, want_rec, go;
  gain_t          att_amt, rec_amt, gain_dn, gain_up;
  logic [GAIN_W:0] up_sum;

  assign want_att = exceed_i || pend_att_q;
  assign want_rec = (rec_req_i || pend_rec_q) && !want_att;
  assign go       = !zc_en_i || zc_i || tmo_hit_i;

  assign att_amt = GAIN_W'(att_sel_i) + GAIN_W'(1);
  assign rec_amt = GAIN_W'(rec_sel_i) + GAIN_W'(1);
  assign gain_dn = (gain_q > att_amt) ? (gain_q - att_amt) : '0;
  assign up_sum  = {1'b0, gain_q} + {1'b0, rec_amt};

  always_comb begin
    if (gain_q >= max_i)                 gain_up = gain_q;
    else if (up_sum > {1'b0, max_i})     gain_up = max_i;
    else                                 gain_up = up_sum[GAIN_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gain_q     <= RESET_GAIN;
      pend_att_q <= 1'b0;
      pend_rec_q <= 1'b0;
    end else if (!active_i) begin
      pend_att_q <= 1'b0;
      pend_rec_q <= 1'b0;
      if (load_i) gain_q <= start_i;
    end else if (go) begin
      pend_att_q <= 1'b0;
      pend_rec_q <= 1'b0;
      if (want_att)      gain_q <= gain_dn;
      else if (want_rec) gain_q <= gain_up;
    end else begin
      pend_att_q <= want_att;
      pend_rec_q <= want_rec;
    end
  end

  assign gain_o = gain_q;
  assign pend_o = pend_att_q || pend_rec_q;

  assert_single_pending_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({pend_att_q, pend_rec_q}));
  assert_hold_inactive_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_i && !load_i) |=> $stable(gain_q));
  assert_gate_holds_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && zc_en_i && !zc_i && !tmo_hit_i) |=> $stable(gain_q));
  assert_drop_on_excess_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && exceed_i && !zc_en_i) |=> (gain_q < $past(gain_q) || $past(gain_q) == '0));
  assert_rise_capped_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_i |=> (gain_q <= $past(gain_q) || gain_q <= $past(max_i)));
endmodule

// File: rtl/alc_gain_engine.sv
module alc_gain_engine
  import alc_pkg::*;
#(
  parameter int    DW         = 16,
  parameter int    WAIT_BASE  = 128,
  parameter gain_t RESET_GAIN = 7'h10,
  parameter gain_t RESET_MAX  = 7'h47
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          smp_valid_i,
  input  logic [DW-1:0] smp_i,
  input  logic          alc_en_i,
  input  logic          path_on_i,
  input  logic          gain_wr_i,
  input  logic [6:0]    start_gain_i,
  input  logic [6:0]    max_gain_i,
  input  logic          lvl_sel_i,
  input  logic [1:0]    att_sel_i,
  input  logic          rec_sel_i,
  input  logic          zc_en_i,
  input  logic [1:0]    tmo_sel_i,
  output logic [6:0]    gain_o
);
  alc_cfg_t cfg_q, cfg_d;
  logic     active, load;
  logic     exceed, zc, rec_req, tmo_hit, pend;

  assign active = alc_en_i && path_on_i;
  assign load   = gain_wr_i && path_on_i && !alc_en_i;

  assign cfg_d = '{lvl_sel: lvl_sel_i, att_sel: att_sel_i, rec_sel: rec_sel_i,
                   zc_en: zc_en_i, tmo_sel: tmo_sel_i, max_gain: max_gain_i};

  // settings shadow: open while control is off
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '{lvl_sel: 1'b0, att_sel: 2'd0, rec_sel: 1'b0,
                            zc_en: 1'b0, tmo_sel: 2'd0, max_gain: RESET_MAX};
    else if (!alc_en_i) cfg_q <= cfg_d;
  end

  alc_level_det #(.DW(DW)) u_det (
    .clk_i, .rst_ni,
    .valid_i   (smp_valid_i),
    .smp_i     (smp_i),
    .lvl_sel_i (cfg_q.lvl_sel),
    .exceed_o  (exceed),
    .zc_o      (zc)
  );

  alc_pacer #(.WAIT_BASE(WAIT_BASE)) u_pacer (
    .clk_i, .rst_ni,
    .active_i  (active),
    .valid_i   (smp_valid_i),
    .exceed_i  (exceed),
    .pend_i    (pend),
    .tmo_sel_i (cfg_q.tmo_sel),
    .rec_req_o (rec_req),
    .tmo_hit_o (tmo_hit)
  );

  alc_gain_reg #(.RESET_GAIN(RESET_GAIN)) u_gain (
    .clk_i, .rst_ni,
    .active_i  (active),
    .load_i    (load),
    .start_i   (start_gain_i),
    .exceed_i  (active && exceed),
    .rec_req_i (rec_req),
    .zc_i      (zc),
    .tmo_hit_i (tmo_hit),
    .zc_en_i   (cfg_q.zc_en),
    .att_sel_i (cfg_q.att_sel),
    .rec_sel_i (cfg_q.rec_sel),
    .max_i     (cfg_q.max_gain),
    .gain_o    (gain_o),
    .pend_o    (pend)
  );

  assert_cfg_frozen_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alc_en_i |=> $stable(cfg_q));
  assert_no_load_running_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gain_wr_i && alc_en_i && !path_on_i) |=> $stable(gain_o));
endmodule

// File: tb/alc_gain_engine_bench.sv
`timescale 1ns/1ps
module alc_gain_engine_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vld = 1'b0;
  logic [15:0] smp = '0;
  logic        en = 1'b0, path = 1'b0, wr = 1'b0;
  logic [6:0]  start = 7'h10, maxg = 7'h47;
  logic        lvl = 1'b0, rec = 1'b0, zce = 1'b0;
  logic [1:0]  att = 2'd0, tmo = 2'd0;
  logic [6:0]  gain;

  int checks = 0, failures = 0;
  logic [6:0] exp_q[$];
  string      tag_q[$];
  logic       due = 1'b0;

  always #5 clk = ~clk;

  alc_gain_engine u_alc_gain_engine (
    .clk_i(clk), .rst_ni(rst_n), .smp_valid_i(vld), .smp_i(smp),
    .alc_en_i(en), .path_on_i(path), .gain_wr_i(wr), .start_gain_i(start),
    .max_gain_i(maxg), .lvl_sel_i(lvl), .att_sel_i(att), .rec_sel_i(rec),
    .zc_en_i(zce), .tmo_sel_i(tmo), .gain_o(gain)
  );

  // monitor: result due one edge after acceptance
  always @(posedge clk) due <= vld;
  always @(negedge clk) begin
    if (due && exp_q.size() > 0) begin
      logic [6:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (gain !== e) begin
        failures++;
        $display("FAIL %s: gain=%h expected=%h", t, gain, e);
      end
    end
  end

  task automatic send(input logic [15:0] s, input logic [6:0] e, input string t);
    @(negedge clk);
    smp = s; vld = 1'b1;
    exp_q.push_back(e); tag_q.push_back(t);
  endtask

  task automatic quiet(input int n, input logic [6:0] e, input string t);
    for (int i = 0; i < n; i++) send(16'd1000, e, t);
  endtask

  task automatic idle(input int n);
    @(negedge clk); vld = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic check_now(input logic [6:0] e, input string t);
    checks++;
    if (gain !== e) begin
      failures++;
      $display("FAIL %s: gain=%h expected=%h", t, gain, e);
    end
  endtask

  task automatic pulse_wr;
    @(negedge clk); wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic set_en(input logic v);
    @(negedge clk); en = v;
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog: run hung");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_now(7'h10, "R1 reset gain");
    rst_n = 1'b1;
    path = 1'b1; start = 7'h14;
    pulse_wr();
    check_now(7'h14, "R2 start load");
    path = 1'b0; start = 7'h30;
    pulse_wr();
    check_now(7'h14, "R2 load ignored path off");
    path = 1'b1;

    set_en(1'b1);
    send(16'd20481, 7'h13, "R3 above level0");
    send(16'd20480, 7'h13, "R3 equal level0");
    send(-16'sd20481, 7'h12, "R3 negative magnitude");
    quiet(100, 7'h12, "R6 quiet before excess");
    send(16'd20481, 7'h11, "R4 one step");
    quiet(127, 7'h11, "R6 wait restarted");
    send(16'd1000, 7'h12, "R5 recovery after period");
    idle(2);
    set_en(1'b0);
    idle(3);
    check_now(7'h12, "R11 frozen on disable");

    maxg = 7'h13; rec = 1'b1; att = 2'd3;
    set_en(1'b1);
    quiet(127, 7'h12, "R5 before period");
    send(16'd1000, 7'h13, "R5 clamp to ceiling");
    quiet(128, 7'h13, "R5 hold at ceiling");
    idle(1);
    maxg = 7'h7F; att = 2'd0; rec = 1'b0; start = 7'h55;
    pulse_wr();
    check_now(7'h13, "R2 load ignored while running");
    send(16'd30000, 7'h0F, "R10 att step frozen");
    quiet(127, 7'h0F, "R10 before period");
    send(16'd1000, 7'h11, "R10 rec step frozen");
    idle(1);

    set_en(1'b0);
    att = 2'd3; start = 7'h02;
    pulse_wr();
    check_now(7'h02, "R2 reload");
    set_en(1'b1);
    send(16'd30000, 7'h00, "R4 saturate at zero");
    send(16'd30000, 7'h00, "R4 floor held");
    idle(1);

    set_en(1'b0);
    zce = 1'b1; att = 2'd0; rec = 1'b0; tmo = 2'd0; maxg = 7'h47; lvl = 1'b1; start = 7'h20;
    pulse_wr();
    check_now(7'h20, "R2 reload zc");
    set_en(1'b1);
    send(16'd16385, 7'h20, "R7 held without crossing");
    send(16'd100, 7'h20, "R7 same sign held");
    send(-16'sd100, 7'h1F, "R7 applied at crossing");
    send(16'd0, 7'h1F, "R7 zero with nothing pending");
    send(16'd16384, 7'h1F, "R3 equal level1");
    send(16'd16385, 7'h1F, "R3 level1 exceed pending");
    quiet(127, 7'h1F, "R8 before timeout");
    send(16'd1000, 7'h1E, "R8 R9 timeout forces attenuation");
    idle(3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule